// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a behavioural, synthesizable model of a single-ported synchronous static RAM in which reads and writes can alternate on every clock with no idle cycle between them. Address, operation, byte-lane enables and the three chip-select inputs are registered on the rising clock edge. Read data flows through to the output in the cycle right after the address edge. Write data for an address cycle is presented one cycle later and is stored at the following enabled edge. The word is made of four nine-bit lanes, each with its own active-low write enable.

An operation starts when the advance input is low: a new address is loaded and the write strobe picks read or write. While advance is high, a four-word burst steps from the loaded address and wraps inside its aligned group of four. The step order is linear or interleaved, chosen by a static order input. An active-low clock enable freezes the whole block. A sleep input blanks the output at once and, after two edges, makes the block ignore its inputs until two edges after it is released. Memory contents are kept through sleep. The data bus is split into a data-in bus, a data-out bus and a drive-enable flag. The data-out bus reads zero whenever the drive flag is low.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted and after it is released, no operation is in progress and `q_oe` is low with `q` zero.
- R2: A load cycle (`adv` low) selects the block only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination starts a deselect cycle: nothing is read or written.
- R3: A selected load with `we_n`=1 is a read. In the cycle after that edge, `q` carries the word at the registered address and `q_oe` is high (flow-through).
- R4: A selected load with `we_n`=0 is a write. The data on `d` is stored at the next enabled edge. A read that is registered at that same edge returns the new data. Reads and writes may alternate on consecutive cycles with no gap.
- R5: Lane i occupies bits [9i+8:9i] and is written only when `bw_n[i]`=0. The lane enables are sampled with each address or continue cycle. A write with all four enables high changes nothing.
- R6: With `adv` high after a selected cycle, the operation type is kept and the burst counter advances. Bits above the lowest two hold the loaded address. With `ilv`=0 the low two bits are (base+n) mod 4. With `ilv`=1 they are base XOR n, where n is the burst step 0..3, wrapping after 3.
- R7: With `adv` high while deselected, the block stays deselected.
- R8: With `cke_n`=1 at an edge, the edge has no effect. The pending write is deferred to the next enabled edge and a read in progress keeps driving.
- R9: `q_oe` is low whenever `oe_n` is high, during write cycles and while deselected.
- R10: `q_oe` is low while `zz` is high. Starting two edges after `zz` rises, edges are ignored. From two edges after `zz` falls, edges take effect again. Contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | Low loads a new address, high continues the burst |
| we_n | input | 1 | Low selects write on a load cycle |
| bw_n | input | LANES | Active-low per-lane write enables |
| addr | input | AW | Word address |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| oe_n | input | 1 | Active-low output enable |
| zz | input | 1 | Sleep request |
| d | input | LANES*LANE_W | Write data |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_oe | output | 1 | High when `q` is being driven |

## Verification
The bench drives the block alongside a behavioural model and compares `q` and `q_oe` on every cycle. It applies linear and interleaved bursts started from unaligned addresses, which separate the two wrap orders and show whether the upper address bits stay put. Strictly alternating write/read pairs on the same address show whether write data is taken one cycle late and whether it is visible to a read on the very next cycle. Partial and empty lane masks, every non-selecting chip-select combination, deselect-continue runs, suspended cycles that hold a pending write while `d` changes, and sleep windows that carry writes are each aimed at one rule. A long random mix then covers the interactions between them.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
   localparam int BURST_LEN = 4;

   // low address bits for burst step n from loaded base bits
   function automatic logic [1:0] burst_low(input logic [1:0] base2,
                                            input logic [1:0] step,
                                            input logic interleave);
      burst_low = interleave ? (base2 ^ step) : (base2 + step);
   endfunction
endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen #(
   parameter int AW = 6
) (
   input  logic [AW-1:0] base,
   input  logic [1:0]    step,
   input  logic          ilv,
   output logic [AW-1:0] cur
);
   import zbt_sram_pkg::*;

   if (AW < 3) begin : g_bad_aw
      $error("zbt_burst_gen: AW must be at least 3");
   end

   assign cur = {base[AW-1:2], burst_low(base[1:0], step, ilv)};
endmodule

// File: rtl/zbt_cycle_ctrl.sv
module zbt_cycle_ctrl #(
   parameter int AW    = 6,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_n,
   input  logic             zz,
   input  logic             sel,
   input  logic             adv,
   input  logic             we_n,
   input  logic [LANES-1:0] bw_n,
   input  logic [AW-1:0]    addr,
   output logic             busy,
   output logic             is_rd,
   output logic [AW-1:0]    base,
   output logic [1:0]       step,
   output logic [LANES-1:0] lane_en,
   output logic             edge_en,
   output logic             commit
);
   logic [1:0] zz_q;

   assign edge_en = ~cke_n & ~zz_q[1];
   assign commit  = edge_en & busy & ~is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zz_q    <= '0;
         busy    <= 1'b0;
         is_rd   <= 1'b0;
         base    <= '0;
         step    <= '0;
         lane_en <= '0;
      end else begin
         zz_q <= {zz_q[0], zz};
         if (edge_en) begin
            if (!adv) begin
               busy <= sel;
               if (sel) begin
                  is_rd   <= we_n;
                  base    <= addr;
                  step    <= '0;
                  lane_en <= ~bw_n;
               end
            end else if (busy) begin
               step    <= step + 2'd1;
               lane_en <= ~bw_n;
            end
         end
      end
   end

   assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> $stable(busy) && $stable(base) && $stable(step) && $stable(is_rd));

   assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && !adv && !sel) |=> !busy);

   assert_continue_keeps_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && adv && busy) |=> busy && $stable(is_rd) && $stable(base));

   assert_deselect_continue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && adv && !busy) |=> !busy);

   assert_sleep_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      zz_q[1] |=> $stable(busy) && $stable(base) && $stable(step));
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW = $clog2(DEPTH),
   localparam int DW = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] lane_en,
   input  logic [AW-1:0]    a,
   input  logic [DW-1:0]    wd,
   output logic [DW-1:0]    rd
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_en[g]) cells[a] <= wd[g*LANE_W +: LANE_W];
      end

      assign rd[g*LANE_W +: LANE_W] = cells[a];
   end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW = $clog2(DEPTH),
   localparam int DW = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_n,
   input  logic             ce_a_n,
   input  logic             ce_b,
   input  logic             ce_c_n,
   input  logic             adv,
   input  logic             we_n,
   input  logic [LANES-1:0] bw_n,
   input  logic [AW-1:0]    addr,
   input  logic             ilv,
   input  logic             oe_n,
   input  logic             zz,
   input  logic [DW-1:0]    d,
   output logic [DW-1:0]    q,
   output logic             q_oe
);
   if (DEPTH < 8 || (DEPTH % zbt_sram_pkg::BURST_LEN) != 0 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("zbt_sram: DEPTH must be a power of two and at least 8");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zbt_sram: LANES and LANE_W must be positive");
   end

   logic             sel;
   logic             busy, is_rd, edge_en, commit;
   logic [AW-1:0]    base, cur;
   logic [1:0]       step;
   logic [LANES-1:0] lane_en;
   logic [DW-1:0]    rd_word;

   assign sel = ~ce_a_n & ce_b & ~ce_c_n;

   zbt_cycle_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .zz(zz), .sel(sel),
      .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .busy(busy), .is_rd(is_rd), .base(base), .step(step),
      .lane_en(lane_en), .edge_en(edge_en), .commit(commit)
   );

   zbt_burst_gen #(.AW(AW)) u_burst (
      .base(base), .step(step), .ilv(ilv), .cur(cur)
   );

   zbt_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we(commit), .lane_en(lane_en), .a(cur), .wd(d), .rd(rd_word)
   );

   assign q_oe = busy & is_rd & ~oe_n & ~zz;
   assign q    = q_oe ? rd_word : '0;

   assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && adv && busy) |=> cur[AW-1:2] == $past(cur[AW-1:2]));

   assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !q_oe);
endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
   localparam int DEPTH = 64;
   localparam int AW    = 6;
   localparam int DW    = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke_n = 1'b0, ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
   logic adv = 1'b1, we_n = 1'b1, ilv = 1'b0, oe_n = 1'b0, zz = 1'b0;
   logic [3:0]    bw_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d = '0;
   logic [DW-1:0] q;
   logic          q_oe;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   zbt_sram #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
      .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .ilv(ilv), .oe_n(oe_n), .zz(zz), .d(d), .q(q), .q_oe(q_oe)
   );

   // behavioural reference
   bit [DW-1:0] ref_mem [DEPTH];
   bit m_act, m_rd, s1, s2, go;
   int m_base, m_step;
   bit [3:0] m_lanes;

   function automatic int m_addr();
      int low;
      low = ilv ? ((m_base % 4) ^ m_step) : ((m_base + m_step) % 4);
      return (m_base / 4) * 4 + low;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_rd = 0; m_base = 0; m_step = 0; m_lanes = 0; s1 = 0; s2 = 0;
      end else begin
         go = !cke_n && !s2;
         s2 = s1;
         s1 = zz;
         if (go) begin
            if (m_act && !m_rd)
               for (int i = 0; i < 4; i++)
                  if (m_lanes[i]) ref_mem[m_addr()][9*i +: 9] = d[9*i +: 9];
            if (!adv) begin
               if (!ce_a_n && ce_b && !ce_c_n) begin
                  m_act = 1; m_rd = we_n; m_base = int'(addr); m_step = 0; m_lanes = ~bw_n;
               end else m_act = 0;
            end else if (m_act) begin
               m_step = (m_step + 1) % 4;
               m_lanes = ~bw_n;
            end
         end
      end
   end

   task automatic chk(string req);
      bit          e_en;
      bit [DW-1:0] e_q;
      e_en = m_act && m_rd && !oe_n && !zz;
      e_q  = e_en ? ref_mem[m_addr()] : '0;
      total++;
      if (q_oe !== e_en || q !== e_q) begin
         bad++;
         $display("FAIL %s: q_oe=%0b q=%h expected q_oe=%0b q=%h", req, q_oe, q, e_en, e_q);
      end
   endtask

   task automatic tick(string req);
      @(negedge clk);
      chk(req);
   endtask

   task automatic issue(string req, bit l_adv, bit l_we_n, int l_addr, bit [3:0] l_bw_n);
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      adv = l_adv; we_n = l_we_n; addr = AW'(l_addr); bw_n = l_bw_n; d = r[DW-1:0];
      tick(req);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) tick("R1");
      rst_n = 1'b1;
      tick("R1");

      // R4 fill every word by write bursts
      for (int b = 0; b < DEPTH / 4; b++) begin
         issue("R4", 0, 0, b * 4, 4'h0);
         for (int k = 0; k < 3; k++) issue("R4", 1, 1, 0, 4'h0);
      end
      issue("R4", 0, 1, 0, 4'hF);

      // R3 single reads, R6 linear bursts from unaligned bases
      for (int k = 0; k < 6; k++) issue("R3", 0, 1, 7 * k + 1, 4'hF);
      ilv = 1'b0;
      for (int b = 0; b < 4; b++) begin
         issue("R6", 0, 1, 9 + 4 * b + b, 4'hF);
         for (int k = 0; k < 5; k++) issue("R6", 1, 1, 0, 4'hF);
      end
      ilv = 1'b1;
      for (int b = 0; b < 4; b++) begin
         issue("R6", 0, 1, 20 + b, 4'hF);
         for (int k = 0; k < 5; k++) issue("R6", 1, 1, 0, 4'hF);
      end
      // interleaved write burst, then read it back
      issue("R6", 0, 0, 42, 4'h0);
      for (int k = 0; k < 3; k++) issue("R6", 1, 0, 0, 4'h0);
      issue("R6", 0, 1, 40, 4'hF);
      for (int k = 0; k < 3; k++) issue("R6", 1, 1, 0, 4'hF);
      ilv = 1'b0;

      // R4 alternating write/read on the same and on other words
      for (int k = 0; k < 8; k++) begin
         issue("R4", 0, 0, 3 * k + 2, 4'h0);
         issue("R4", 0, 1, 3 * k + 2, 4'hF);
         issue("R4", 0, 1, 3 * k + 5, 4'hF);
      end

      // R5 partial lane masks and write abort
      begin
         bit [3:0] masks [6] = '{4'b1110, 4'b0101, 4'b1111, 4'b0111, 4'b1010, 4'b1111};
         foreach (masks[i]) begin
            issue("R5", 0, 0, 33, masks[i]);
            issue("R5", 0, 1, 33, 4'hF);
         end
         issue("R5", 0, 0, 48, 4'b0011);
         issue("R5", 1, 0, 0, 4'b1100);
         issue("R5", 1, 0, 0, 4'b1111);
         issue("R5", 0, 1, 48, 4'hF);
         for (int k = 0; k < 3; k++) issue("R5", 1, 1, 0, 4'hF);
      end

      // R2 every non-selecting chip-select combination
      for (int c = 0; c < 8; c++) begin
         if (c != 3'b010) begin
            {ce_c_n, ce_b, ce_a_n} = 3'(c);
            issue("R2", 0, 0, 12, 4'h0);
            issue("R2", 0, 1, 12, 4'hF);
            ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
            issue("R2", 0, 1, 12, 4'hF);
            issue("R2", 1, 1, 0, 4'hF);
         end
      end

      // R7 deselect then continue cycles
      ce_a_n = 1'b1;
      issue("R7", 0, 1, 5, 4'hF);
      ce_a_n = 1'b0;
      for (int k = 0; k < 4; k++) issue("R7", 1, k[0], 0, 4'h0);
      issue("R7", 0, 1, 5, 4'hF);

      // R9 output enable gating and write cycles
      issue("R9", 0, 1, 17, 4'hF);
      oe_n = 1'b1;
      tick("R9");
      issue("R9", 1, 1, 0, 4'hF);
      oe_n = 1'b0;
      issue("R9", 0, 0, 18, 4'h0);
      issue("R9", 1, 0, 0, 4'h0);
      issue("R9", 0, 1, 18, 4'hF);

      // R8 suspend during read burst and with a pending write
      issue("R8", 0, 1, 26, 4'hF);
      cke_n = 1'b1;
      for (int k = 0; k < 3; k++) issue("R8", k[0], 0, 50, 4'h0);
      cke_n = 1'b0;
      issue("R8", 1, 1, 0, 4'hF);
      issue("R8", 0, 0, 30, 4'h0);
      cke_n = 1'b1;
      for (int k = 0; k < 3; k++) issue("R8", 0, 1, 60, 4'hF);
      cke_n = 1'b0;
      issue("R8", 0, 1, 30, 4'hF);
      issue("R8", 0, 1, 30, 4'hF);

      // R10 sleep window carrying writes
      issue("R10", 0, 1, 44, 4'hF);
      zz = 1'b1;
      for (int k = 0; k < 6; k++) issue("R10", 0, 0, 44 + k, 4'h0);
      zz = 1'b0;
      for (int k = 0; k < 3; k++) issue("R10", 1, 1, 0, 4'hF);
      for (int k = 0; k < 8; k++) issue("R10", 0, 1, 44 + k, 4'hF);

      // random mix
      for (int k = 0; k < 500; k++) begin
         cke_n  = ($urandom_range(0, 9) == 0);
         ce_a_n = ($urandom_range(0, 9) == 0);
         ce_b   = ($urandom_range(0, 9) != 0);
         ce_c_n = ($urandom_range(0, 9) == 0);
         oe_n   = ($urandom_range(0, 7) == 0);
         if ((k % 100) == 0) ilv = ~ilv;
         issue("R4", $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, DEPTH - 1), 4'($urandom_range(0, 15)));
      end
      cke_n = 1'b0; ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0; oe_n = 1'b0;
      for (int a = 0; a < DEPTH; a++) issue("R3", 0, 1, a, 4'hF);
      tick("R3");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule